// File: doc/BRIEF.md
# Funnel Shifter with Hidden Fill Operand

This block shifts a base vector left or right by an unsigned amount. The positions that open up are not filled with zeros or sign copies. They are filled from a second operand, the hidden vector, which has its own width. The hidden width also sets the largest shift that has meaning: a shift by exactly that width pushes the whole hidden vector through the window.

A left shift joins the base above the hidden vector and reads a window of base width from that joined word. The window's top sits `amount` places below the top of the word. A right shift joins the hidden vector above the base and reads a window whose bottom sits `amount` places above the bottom of the word. An amount larger than the hidden width raises an error flag, and the result is then pinned to the fully shifted value.

A parameter selects whether the result and the flag leave through a register stage or straight from the logic. The block has no state machine. The single register stage has two conditions: cleared while reset is held, and loading the new result otherwise.

Top module: `funnel_shift`

## Requirements
- R1: When `amt_i` is zero, `res_o` equals `base_i` unchanged, in both directions.
- R2: With `dir_i` = 0 (left), the word `{base_i, hidden_i}` is formed with the base in the upper part. Bit i of `res_o` equals bit `HIDDEN_W + i - amt` of that word.
- R3: With `dir_i` = 1 (right), the word `{hidden_i, base_i}` is formed with the base in the lower part. Bit i of `res_o` equals bit `i + amt` of that word.
- R4: The amount is unsigned, and every value from 0 through `HIDDEN_W` is legal. With `HIDDEN_W >= BASE_W` and amount `HIDDEN_W`, a left shift yields `hidden_i[BASE_W-1:0]` and a right shift yields `hidden_i[HIDDEN_W-1 -: BASE_W]`.
- R5: When `amt_i > HIDDEN_W`, `amt_err_o` is 1 and `res_o` equals the result for an amount of exactly `HIDDEN_W`.
- R6: When `amt_i <= HIDDEN_W`, `amt_err_o` is 0.
- R7: With `REG_OUT` = 1, `res_o` and `amt_err_o` show the inputs sampled at the previous rising edge of `clk`. With `REG_OUT` = 0, they follow the inputs with no clock.
- R8: With `REG_OUT` = 1, a high `rst` sampled at a rising edge clears `res_o` and `amt_err_o` to 0.
- R9: With default widths, base 8'b10011001, hidden 12'b010110100101 and amount 6 give 8'b01010110 for a left shift and 8'b10010110 for a right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| base_i | input | BASE_W | Vector being shifted |
| hidden_i | input | HIDDEN_W | Operand that supplies the shifted-in bits |
| amt_i | input | AMT_W | Unsigned shift amount |
| dir_i | input | 1 | Direction: 0 left, 1 right |
| res_o | output | BASE_W | Shifted window |
| amt_err_o | output | 1 | Amount exceeded HIDDEN_W |

## Verification
The bench aims at the edges of the amount range: zero, exactly the hidden width, one past it, and the largest encodable amount. A design that mishandles these would pass the base through with an offset, would flag a legal full shift as an error, or would let an oversized amount wrap round and pick up stale base bits. Both directions are checked against a bit-indexed model of the joined word. A second instance has a hidden operand narrower than the base and no output register. This catches any design that assumes the fill covers the whole window, and any design that adds a cycle of delay where none belongs. A reset applied in the middle of a run, while the inputs stay nonzero, must clear a registered result. A stage with a broken reset would leave the old value in place.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    // Direction select encoding shared by the datapath and its checks.
    typedef enum logic {
        SH_LEFT  = 1'b0,
        SH_RIGHT = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/fsh_amt_clamp.sv
module fsh_amt_clamp #(
    parameter int HIDDEN_W = 12,
    parameter int AMT_W    = 5,
    parameter int CAMT_W   = 4
) (
    input  logic [AMT_W-1:0]  amt_i,
    output logic [CAMT_W-1:0] camt_o,
    output logic              over_o
);
    // The compare width holds both the raw amount and the limit, with spare headroom.
    localparam int CMP_W = ((AMT_W > CAMT_W) ? AMT_W : CAMT_W) + 1;

    logic [CMP_W-1:0] amt_ext;
    logic [CMP_W-1:0] limit;

    always_comb begin
        amt_ext = CMP_W'(amt_i);
        limit   = CMP_W'(HIDDEN_W);
        over_o  = (amt_ext > limit);
        // A legal amount fits in CAMT_W bits, so the truncation loses nothing.
        camt_o  = over_o ? CAMT_W'(HIDDEN_W) : CAMT_W'(amt_ext);
    end

endmodule

// File: rtl/fsh_core.sv
module fsh_core
    import fsh_pkg::*;
#(
    parameter int BASE_W   = 8,
    parameter int HIDDEN_W = 12,
    parameter int CAMT_W   = 4
) (
    input  logic [BASE_W-1:0]   base_i,
    input  logic [HIDDEN_W-1:0] hidden_i,
    input  logic [CAMT_W-1:0]   amt_i,
    input  shift_dir_e          dir_i,
    output logic [BASE_W-1:0]   res_o
);
    localparam int TOT_W = BASE_W + HIDDEN_W;

    logic [TOT_W-1:0] word;

    // Logarithmic funnel: stage k moves the joined word by 2**k when amount bit k is set.
    always_comb begin
        if (dir_i == SH_LEFT) begin
            word = {base_i, hidden_i};
        end else begin
            word = {hidden_i, base_i};
        end
        for (int k = 0; k < CAMT_W; k++) begin
            if (amt_i[k]) begin
                if (dir_i == SH_LEFT) begin
                    word = word << (1 << k);
                end else begin
                    word = word >> (1 << k);
                end
            end
        end
        if (dir_i == SH_LEFT) begin
            res_o = word[TOT_W-1 -: BASE_W];
        end else begin
            res_o = word[BASE_W-1:0];
        end
    end

endmodule

// File: rtl/fsh_outreg.sv
module fsh_outreg #(
    parameter int DATA_W  = 9,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    generate
        if (REG_OUT) begin : g_reg
            logic [DATA_W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r <= '0;
                end else begin
                    q_r <= d_i;
                end
            end
            assign q_o = q_r;
        end else begin : g_pass
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/funnel_shift.sv
module funnel_shift
    import fsh_pkg::*;
#(
    parameter int BASE_W   = 8,
    parameter int HIDDEN_W = 12,
    parameter int AMT_W    = 5,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BASE_W-1:0]   base_i,
    input  logic [HIDDEN_W-1:0] hidden_i,
    input  logic [AMT_W-1:0]    amt_i,
    input  logic                dir_i,
    output logic [BASE_W-1:0]   res_o,
    output logic                amt_err_o
);
    localparam int CAMT_W = (HIDDEN_W < 2) ? 1 : $clog2(HIDDEN_W + 1);
    localparam int OUT_W  = BASE_W + 1;

    logic [CAMT_W-1:0] camt;
    logic              over;
    logic [BASE_W-1:0] res_c;
    logic [OUT_W-1:0]  out_q;
    shift_dir_e        dir_e;

    assign dir_e = shift_dir_e'(dir_i);

    fsh_amt_clamp #(
        .HIDDEN_W (HIDDEN_W),
        .AMT_W    (AMT_W),
        .CAMT_W   (CAMT_W)
    ) u_clamp (
        .amt_i  (amt_i),
        .camt_o (camt),
        .over_o (over)
    );

    fsh_core #(
        .BASE_W   (BASE_W),
        .HIDDEN_W (HIDDEN_W),
        .CAMT_W   (CAMT_W)
    ) u_core (
        .base_i   (base_i),
        .hidden_i (hidden_i),
        .amt_i    (camt),
        .dir_i    (dir_e),
        .res_o    (res_c)
    );

    fsh_outreg #(
        .DATA_W  (OUT_W),
        .REG_OUT (REG_OUT)
    ) u_oreg (
        .clk (clk),
        .rst (rst),
        .d_i ({over, res_c}),
        .q_o (out_q)
    );

    assign amt_err_o = out_q[OUT_W-1];
    assign res_o     = out_q[BASE_W-1:0];

    generate
        if (REG_OUT) begin : g_chk_reg
            // R1
            zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
                (amt_i == '0) |=> (res_o == $past(base_i)));
            // R6
            no_err_chk: assert property (@(posedge clk) disable iff (rst)
                (32'(amt_i) <= HIDDEN_W) |=> !amt_err_o);
            // R5
            err_flag_chk: assert property (@(posedge clk) disable iff (rst)
                (32'(amt_i) > HIDDEN_W) |=> amt_err_o);
            // R8
            rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> (res_o == '0 && !amt_err_o));
            if (HIDDEN_W >= BASE_W) begin : g_full
                // R4
                full_left_chk: assert property (@(posedge clk) disable iff (rst)
                    (32'(amt_i) >= HIDDEN_W && dir_i == 1'b0)
                    |=> (res_o == $past(hidden_i[BASE_W-1:0])));
                // R4
                full_right_chk: assert property (@(posedge clk) disable iff (rst)
                    (32'(amt_i) >= HIDDEN_W && dir_i == 1'b1)
                    |=> (res_o == $past(hidden_i[HIDDEN_W-1 -: BASE_W])));
            end
        end else begin : g_chk_comb
            // R1
            zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
                (amt_i == '0) |-> (res_o == base_i));
            // R6
            no_err_chk: assert property (@(posedge clk) disable iff (rst)
                (32'(amt_i) <= HIDDEN_W) |-> !amt_err_o);
            // R5
            err_flag_chk: assert property (@(posedge clk) disable iff (rst)
                (32'(amt_i) > HIDDEN_W) |-> amt_err_o);
            if (HIDDEN_W >= BASE_W) begin : g_full
                // R4
                full_left_chk: assert property (@(posedge clk) disable iff (rst)
                    (32'(amt_i) >= HIDDEN_W && dir_i == 1'b0)
                    |-> (res_o == hidden_i[BASE_W-1:0]));
            end
        end
    endgenerate

endmodule

// File: tb/funnel_shift_bench.sv
`timescale 1ns/1ps
module funnel_shift_bench;
    localparam int MB = 8;
    localparam int MH = 12;
    localparam int MA = 5;
    localparam int NB = 12;
    localparam int NH = 5;
    localparam int NA = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [MB-1:0] m_base = '0;
    logic [MH-1:0] m_hid  = '0;
    logic [MA-1:0] m_amt  = '0;
    logic          m_dir  = 1'b0;
    logic [MB-1:0] m_res;
    logic          m_err;

    logic [NB-1:0] n_base = '0;
    logic [NH-1:0] n_hid  = '0;
    logic [NA-1:0] n_amt  = '0;
    logic          n_dir  = 1'b0;
    logic [NB-1:0] n_res;
    logic          n_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [MB-1:0] q_res[$];
    logic          q_err[$];
    string         q_tag[$];

    funnel_shift #(.BASE_W(MB), .HIDDEN_W(MH), .AMT_W(MA), .REG_OUT(1'b1)) u_funnel_shift (
        .clk(clk), .rst(rst), .base_i(m_base), .hidden_i(m_hid), .amt_i(m_amt),
        .dir_i(m_dir), .res_o(m_res), .amt_err_o(m_err));

    funnel_shift #(.BASE_W(NB), .HIDDEN_W(NH), .AMT_W(NA), .REG_OUT(1'b0)) u_funnel_shift_narrow (
        .clk(clk), .rst(rst), .base_i(n_base), .hidden_i(n_hid), .amt_i(n_amt),
        .dir_i(n_dir), .res_o(n_res), .amt_err_o(n_err));

    // Bit-indexed model of the joined word; an oversized amount is pinned at hw.
    function automatic logic [31:0] model(input logic [31:0] b, input logic [31:0] h,
                                          input int bw, input int hw, input int amt, input bit dir);
        logic [63:0] j;
        logic [31:0] r;
        int eff;
        eff = (amt > hw) ? hw : amt;
        j = '0;
        r = '0;
        for (int k = 0; k < bw + hw; k++) begin
            if (!dir) j[k] = (k < hw) ? h[k] : b[k - hw];
            else      j[k] = (k < bw) ? b[k] : h[k - bw];
        end
        for (int i = 0; i < bw; i++) begin
            r[i] = dir ? j[i + eff] : j[hw + i - eff];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: apply one vector to the registered instance and queue its expected outcome.
    task automatic apply(input logic [MB-1:0] b, input logic [MH-1:0] h,
                         input int a, input bit d, input string tag);
        @(negedge clk);
        m_base = b; m_hid = h; m_amt = MA'(a); m_dir = d;
        q_res.push_back(MB'(model(32'(b), 32'(h), MB, MH, a, d)));
        q_err.push_back(a > MH);
        q_tag.push_back(tag);
    endtask

    // Monitor: one register of latency, sampled 1 ns after the capturing edge.
    always @(posedge clk) begin
        #1;
        if (q_res.size() > 0) begin
            logic [MB-1:0] er;
            logic ee;
            string t;
            er = q_res.pop_front();
            ee = q_err.pop_front();
            t  = q_tag.pop_front();
            check({t, " result"}, 32'(m_res), 32'(er));
            check({t, " flag"}, 32'(m_err), 32'(ee));
        end
    end

    // Narrow instance has no register: settle and compare directly.
    task automatic apply_narrow(input logic [NB-1:0] b, input logic [NH-1:0] h,
                                input int a, input bit d, input string tag);
        @(negedge clk);
        n_base = b; n_hid = h; n_amt = NA'(a); n_dir = d;
        #1;
        check({tag, " narrow result"}, 32'(n_res), model(32'(b), 32'(h), NB, NH, a, d));
        check({tag, " narrow flag"}, 32'(n_err), 32'(a > NH));
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset res", 32'(m_res), 32'd0);
        check("R8 reset flag", 32'(m_err), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R9: known vector, both directions (R2 left, R3 right)
        apply(8'b10011001, 12'b010110100101, 6, 1'b0, "R9 R2 vector left");
        apply(8'b10011001, 12'b010110100101, 6, 1'b1, "R9 R3 vector right");
        // R1: zero amount
        apply(8'hA5, 12'hFFF, 0, 1'b0, "R1 zero left");
        apply(8'h3C, 12'h000, 0, 1'b1, "R1 zero right");
        // R4: exactly the hidden width
        apply(8'h00, 12'hB7E, MH, 1'b0, "R4 full left");
        apply(8'hFF, 12'hB7E, MH, 1'b1, "R4 full right");
        // R5: one past, and the largest encodable amount
        apply(8'h5A, 12'h9C3, MH + 1, 1'b0, "R5 over left");
        apply(8'h5A, 12'h9C3, 31, 1'b1, "R5 max right");
        // R6, R2, R3, R7: sweep every legal amount, back to back
        for (int a = 0; a <= MH; a++) begin
            apply(8'hC6, 12'h4D1, a, a[0], "R6 R7 sweep");
        end
        // R2 R3 R5: random vectors
        for (int n = 0; n < 200; n++) begin
            apply(MB'($urandom), MH'($urandom), int'($urandom_range(0, 31)),
                  1'($urandom), "R2 R3 R5 random");
        end
        repeat (3) @(posedge clk);

        // R8: reset mid-run with nonzero inputs
        @(negedge clk);
        m_base = 8'hFF; m_hid = 12'hFFF; m_amt = 5'd20; m_dir = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 mid reset res", 32'(m_res), 32'd0);
        check("R8 mid reset flag", 32'(m_err), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R7 comb mode, hidden narrower than base (R2 R3 R5 R6)
        apply_narrow(12'hABC, 5'h13, 0, 1'b0, "R1 R7");
        apply_narrow(12'hABC, 5'h13, NH, 1'b0, "R2 R7 full");
        apply_narrow(12'hABC, 5'h13, NH, 1'b1, "R3 R7 full");
        apply_narrow(12'h123, 5'h1F, 15, 1'b1, "R5 R7 over");
        for (int n = 0; n < 100; n++) begin
            apply_narrow(NB'($urandom), NH'($urandom), int'($urandom_range(0, 15)),
                         1'($urandom), "R2 R3 R6 R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule